// File: doc/BRIEF.md
# Laser Driver Interrupt Collector

This block collects three interrupt events for a pulsed laser driver and presents them through a sticky source register, a mask register and a derived pending view. A single active-high interrupt request is raised while any unmasked source bit is held. One source follows the driver pulse level. The other two are edge events on an active-low over-temperature warning line, which first passes through a synchronizer.

Software uses a plain register port: one write strobe, an address, write data, and a read-data bus that decodes the address combinationally. Source bits are cleared by writing ones to them. The same port also holds a driver-enable bit, which drives an output pin. It can also read back the synchronized warning level. The port has no handshake: a write takes effect on the clock edge where the strobe is high. Read data is valid in the same cycle as the address.

Top module: `ldrv_irq_ctl`

## Requirements
- R1: After reset the mask register (0xA0) reads 7, the source register (0xA4) reads 0, the enable register (0x80) reads 0, `drv_en_o` is 0 and `irq_o` is 0.
- R2: On each clock edge where `pulse_i` is high, source bit 0 is set.
- R3: A low-to-high change of `warn_n_i` sets source bit 1. The bit is set on the third rising clock edge after the input changes.
- R4: A high-to-low change of `warn_n_i` sets source bit 2, with the same three-edge latency as R3.
- R5: A write to 0xA4 clears each source bit whose write-data bit is 1 and leaves the others unchanged.
- R6: If an event and a clear of the same source bit fall on the same edge, the bit ends up set.
- R7: Reading 0xA8 returns source AND NOT mask in bits [2:0]. Writes to 0xA8 have no effect.
- R8: `irq_o` is high exactly when at least one pending bit is set.
- R9: A write to 0xA0 loads write-data bits [2:0] into the mask, where a 1 masks that source. Bits above bit 2 read as 0 at every mapped offset.
- R10: A write to 0x80 loads write-data bit 0 into the enable register. The enable register drives `drv_en_o` and reads back in bit 0.
- R11: Reading 0x84 returns the synchronized `warn_n_i` level in bit 0. The level appears two rising edges after the input changes.
- R12: Reads from unmapped offsets return 0. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | Generated driver pulse, already synchronous to clk |
| warn_n_i | input | 1 | Over-temperature warning, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| drv_en_o | output | 1 | Driver enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Writes and pulse events are due one edge after the strobe or pulse, so the bench samples them at the falling edge that follows. Read data and `irq_o` are combinational from the registers and are sampled in the same half cycle as the address. Warning edges are counted explicitly. The level at 0x84 is checked as still high one edge after the input falls and as low after two edges. The matching source bit is checked as clear after two edges and as set after three. A same-edge pulse and clear is driven to check that the set wins.

// File: rtl/ldrv_irq_pkg.sv
package ldrv_irq_pkg;
  localparam int NSRC      = 3;
  localparam int SRC_PULSE = 0;
  localparam int SRC_WRISE = 1;
  localparam int SRC_WFALL = 2;

  localparam logic [7:0] OFS_EN   = 8'h80;
  localparam logic [7:0] OFS_WARN = 8'h84;
  localparam logic [7:0] OFS_MASK = 8'hA0;
  localparam logic [7:0] OFS_SRC  = 8'hA4;
  localparam logic [7:0] OFS_PEND = 8'hA8;
endpackage

// File: rtl/ldrv_warn_sync.sv
module ldrv_warn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_n_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // Each stage resets to the idle (high) level, so that leaving reset raises no false edge.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= warn_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
  assign fall_o  = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/ldrv_irq_bank.sv
module ldrv_irq_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            mask_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wr_bits,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] src_q,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wr_bits;
  end

  genvar b;
  generate
    for (b = 0; b < NSRC; b++) begin : g_src
      logic kill;
      assign kill = clr_we & wr_bits[b];
      always_ff @(posedge clk) begin
        if (!rst_n) src_q[b] <= 1'b0;
        else        src_q[b] <= evt_i[b] | (src_q[b] & ~kill);
      end
    end
  endgenerate

  assign pend_o = src_q & ~mask_q;
  assign irq_o  = |pend_o;
endmodule

// File: rtl/ldrv_ctl_regs.sv
module ldrv_ctl_regs
  import ldrv_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              warn_lvl,
  input  logic [NS-1:0]     mask_q,
  input  logic [NS-1:0]     src_q,
  input  logic [NS-1:0]     pend,
  output logic              drv_en_o,
  output logic [DATA_W-1:0] rdata,
  output logic              mask_we,
  output logic              clr_we,
  output logic [NS-1:0]     wr_bits
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_WARN = ADDR_W'(OFS_WARN);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);

  logic en_q;
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:NS];

  assign mask_we = we && (addr == A_MASK);
  assign clr_we  = we && (addr == A_SRC);
  assign wr_bits = wdata[NS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                     en_q <= 1'b0;
    else if (we && (addr == A_EN))  en_q <= wdata[0];
  end
  assign drv_en_o = en_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN:    rdata[0]      = en_q;
      A_WARN:  rdata[0]      = warn_lvl;
      A_MASK:  rdata[NS-1:0] = mask_q;
      A_SRC:   rdata[NS-1:0] = src_q;
      A_PEND:  rdata[NS-1:0] = pend;
      default: rdata         = '0;
    endcase
  end
endmodule

// File: rtl/ldrv_irq_ctl.sv
module ldrv_irq_ctl
  import ldrv_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_i,
  input  logic              warn_n_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              drv_en_o,
  output logic              irq_o
);
  logic            warn_lvl, warn_rise, warn_fall;
  logic [NSRC-1:0] evt, mask_q, src_q, pend;
  logic            mask_we, clr_we;
  logic [NSRC-1:0] wr_bits;

  ldrv_warn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .warn_n_i(warn_n_i),
    .level_o(warn_lvl), .rise_o(warn_rise), .fall_o(warn_fall)
  );

  always_comb begin
    evt            = '0;
    evt[SRC_PULSE] = pulse_i;
    evt[SRC_WRISE] = warn_rise;
    evt[SRC_WFALL] = warn_fall;
  end

  ldrv_irq_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .mask_we(mask_we), .clr_we(clr_we), .wr_bits(wr_bits),
    .mask_q(mask_q), .src_q(src_q), .pend_o(pend), .irq_o(irq_o)
  );

  ldrv_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .warn_lvl(warn_lvl), .mask_q(mask_q), .src_q(src_q), .pend(pend),
    .drv_en_o(drv_en_o), .rdata(reg_rdata),
    .mask_we(mask_we), .clr_we(clr_we), .wr_bits(wr_bits)
  );
endmodule

// File: rtl/ldrv_irq_ctl_chk.sv
module ldrv_irq_ctl_chk
  import ldrv_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NS     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_i,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              drv_en_o,
  input logic              irq_o,
  input logic [NS-1:0]     src_q,
  input logic [NS-1:0]     mask_q
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFS_SRC);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '1 && src_q == '0 && !drv_en_o));

  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> src_q[SRC_PULSE]);

  p_clear_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SRC && reg_wdata[0] && !pulse_i) |=> !src_q[SRC_PULSE]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SRC && reg_wdata[0] && pulse_i) |=> src_q[SRC_PULSE]);

  p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(src_q & ~mask_q)));

  p_enable_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EN) |=> (drv_en_o == $past(reg_wdata[0])));
endmodule

bind ldrv_irq_ctl ldrv_irq_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .drv_en_o(drv_en_o),
  .irq_o(irq_o), .src_q(src_q), .mask_q(mask_q)
);

// File: tb/ldrv_irq_ctl_test.sv
module ldrv_irq_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_i = 1'b0;
  logic        warn_n_i = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        drv_en_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldrv_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .warn_n_i(warn_n_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .drv_en_o(drv_en_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read and compare, 2 one-cycle pulse, 3 set warning level and settle
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 4'd1,  8'hA0, 32'h0, 32'h7, 1'b0},        // R1 R9 mask resets to all ones
    '{2'd1, 4'd1,  8'hA4, 32'h0, 32'h0, 1'b0},        // R1 sources start clear
    '{2'd1, 4'd1,  8'h80, 32'h0, 32'h0, 1'b0},        // R1 enable starts low
    '{2'd1, 4'd11, 8'h84, 32'h0, 32'h1, 1'b0},        // R11 idle warning level
    '{2'd2, 4'd2,  8'h00, 32'h0, 32'h0, 1'b0},
    '{2'd1, 4'd2,  8'hA4, 32'h0, 32'h1, 1'b0},        // R2 pulse latched, still masked
    '{2'd1, 4'd7,  8'hA8, 32'h0, 32'h0, 1'b0},        // R7 masked bit not pending
    '{2'd0, 4'd9,  8'hA0, 32'h6, 32'h0, 1'b0},
    '{2'd1, 4'd8,  8'hA8, 32'h0, 32'h1, 1'b1},        // R7 R8 unmasked pulse raises irq
    '{2'd0, 4'd5,  8'hA4, 32'h1, 32'h0, 1'b0},
    '{2'd1, 4'd5,  8'hA4, 32'h0, 32'h0, 1'b0},        // R5 write-one clear
    '{2'd3, 4'd4,  8'h00, 32'h0, 32'h0, 1'b0},
    '{2'd1, 4'd4,  8'hA4, 32'h0, 32'h4, 1'b0},        // R4 falling warning edge
    '{2'd1, 4'd11, 8'h84, 32'h0, 32'h0, 1'b0},        // R11 level low
    '{2'd3, 4'd3,  8'h00, 32'h1, 32'h0, 1'b0},
    '{2'd1, 4'd3,  8'hA4, 32'h0, 32'h6, 1'b0},        // R3 rising warning edge
    '{2'd0, 4'd9,  8'hA0, 32'h3, 32'h0, 1'b0},
    '{2'd1, 4'd8,  8'hA8, 32'h0, 32'h4, 1'b1},        // R8 bit 2 pending
    '{2'd0, 4'd5,  8'hA4, 32'h2, 32'h0, 1'b0},
    '{2'd1, 4'd5,  8'hA4, 32'h0, 32'h4, 1'b1},        // R5 only bit 1 cleared
    '{2'd0, 4'd7,  8'hA8, 32'h7, 32'h0, 1'b0},
    '{2'd1, 4'd7,  8'hA4, 32'h0, 32'h4, 1'b1},        // R7 pending write ignored
    '{2'd0, 4'd10, 8'h80, 32'h1, 32'h0, 1'b0},
    '{2'd1, 4'd10, 8'h80, 32'h0, 32'h1, 1'b1},        // R10 enable readback
    '{2'd0, 4'd9,  8'hA0, 32'hFFFFFFF8, 32'h0, 1'b0},
    '{2'd1, 4'd9,  8'hA0, 32'h0, 32'h0, 1'b1},        // R9 only low bits stored
    '{2'd0, 4'd12, 8'h90, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{2'd1, 4'd12, 8'h90, 32'h0, 32'h0, 1'b1},        // R12 unmapped reads zero
    '{2'd1, 4'd12, 8'hA4, 32'h0, 32'h4, 1'b1}         // R12 unmapped write touched nothing
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h, want %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tick();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got hung run, want completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 drv_en after reset", {31'b0, drv_en_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: wr(TBL[i].addr, TBL[i].data);
        2'd1: begin
          tick();
          rd_chk($sformatf("R%0d read %02h", TBL[i].req, TBL[i].addr), TBL[i].addr, TBL[i].exp);
          check($sformatf("R%0d irq", TBL[i].req), {31'b0, irq_o}, {31'b0, TBL[i].exp_irq});
        end
        2'd2: begin
          tick(); pulse_i = 1'b1;
          tick(); pulse_i = 1'b0;
        end
        default: begin
          tick(); warn_n_i = TBL[i].data[0];
          repeat (4) tick();
        end
      endcase
    end

    // R10: pin follows the enable register
    check("R10 drv_en pin", {31'b0, drv_en_o}, 32'h1);

    // R6: pulse and clear of bit 0 on the same edge; the set must win
    wr(8'hA4, 32'h7);
    tick();
    pulse_i = 1'b1; reg_we = 1'b1; reg_addr = 8'hA4; reg_wdata = 32'h1;
    tick();
    pulse_i = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    rd_chk("R6 set beats clear", 8'hA4, 32'h1);

    // R3 R4 R11: count edges through the synchronizer
    wr(8'hA4, 32'h7);
    warn_n_i = 1'b0;
    tick();
    rd_chk("R11 level after one edge", 8'h84, 32'h1);
    tick();
    rd_chk("R11 level after two edges", 8'h84, 32'h0);
    rd_chk("R4 bit2 not yet after two edges", 8'hA4, 32'h0);
    tick();
    rd_chk("R4 bit2 after three edges", 8'hA4, 32'h4);
    warn_n_i = 1'b1;
    tick(); tick();
    rd_chk("R3 bit1 not yet after two edges", 8'hA4, 32'h4);
    tick();
    rd_chk("R3 bit1 after three edges", 8'hA4, 32'h6);

    // R1: reset in mid-run restores every register
    wr(8'hA0, 32'h0);
    check("R8 irq before reset", {31'b0, irq_o}, 32'h1);
    tick(); rst_n = 1'b0;
    tick(); rst_n = 1'b1;
    rd_chk("R1 mask after reset", 8'hA0, 32'h7);
    rd_chk("R1 source after reset", 8'hA4, 32'h0);
    rd_chk("R1 enable after reset", 8'h80, 32'h0);
    check("R1 irq after second reset", {31'b0, irq_o}, 32'h0);
    check("R1 drv_en after second reset", {31'b0, drv_en_o}, 32'h0);

    summary();
    $finish;
  end
endmodule